// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Interface

This block sits between a host processor bus and a bank of sixteen internal 16-bit registers. It also raises a one-clock request toward a memory controller whenever the host opens a memory cycle. A static mode input picks how the shared bus pins are read. In split-strobe mode the host uses separate read and write strobes, and the ready pin asks the host to add wait states. In acknowledge mode the read-strobe pin is an address strobe, the write-strobe pin is a read/write line, address bit 0 and the byte-high-enable pin are the upper and lower data strobes, and the ready pin signals that the transfer has finished.

Every host strobe and select is treated as asynchronous and passes through a two-flop synchronizer. A register cycle runs a small sequencer. It drives the ready pin from the start of the cycle, holds the waiting level for a fixed number of clocks, then commits any write and drives the completion level until the host withdraws the cycle. After that the pin is released. A width input narrows split-strobe mode to an 8-bit data path, in which address bit 0 selects the byte of the register.

Top module: `host_bus_regif`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears to 0 and `rdy_oe`, `data_oe` and `mem_req` go low.
- R2: In split-strobe 16-bit mode (`mode_ack`=0, `bus8`=0), a write cycle (`reg_sel_n` and `strb_wr_n` low) writes register `reg_addr[4:1]`. The low byte is written only when `reg_addr[0]`=0 and the high byte only when `bhe_n`=0. A byte that is not enabled keeps its value.
- R3: During a register read cycle, `data_out` carries the addressed register and `data_oe` is 1 from the third clock after the strobe falls until the synchronized strobe rises. `data_oe` stays 0 throughout write cycles.
- R4: In split-strobe mode, `rdy_oe` rises at the third clock after the strobe falls. `rdy_out` is 0 for the next two clocks and then 1 until release.
- R5: In acknowledge mode, after the address strobe (`strb_rd_n`) falls with `reg_sel_n` low, `rdy_out` is driven 1 for two clocks and then 0 (acknowledge) until the strobe rises.
- R6: `rdy_oe` drops to 0 on the third clock after the host ends the cycle. Strobes that arrive while `reg_sel_n` is high never drive `rdy_oe` and do not alter any register.
- R7: In acknowledge mode, `strb_wr_n`=1 means read and 0 means write. The high byte is written when `reg_addr[0]`=0 (upper data strobe) and the low byte when `bhe_n`=0 (lower data strobe).
- R8: In 8-bit mode (`bus8`=1), writes take `data_in[7:0]` into the low byte when `reg_addr[0]`=0 and into the high byte when it is 1, and `bhe_n` and `data_in[15:8]` have no effect. Reads return the selected byte on `data_out[7:0]`, with `data_out[15:8]`=0.
- R9: In split-strobe mode, `mem_sel_n` low together with `mem_wr_n` or `mem_rd_n` low produces exactly one `mem_req` pulse per cycle. `mem_we` is 1 for a write and 0 for a read.
- R10: In acknowledge mode, a memory cycle is `mem_sel_n` low with the address strobe low, and its direction comes from `strb_wr_n`. `mem_rd_n` and `mem_wr_n` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ack | input | 1 | 0 split-strobe bus, 1 acknowledge bus |
| bus8 | input | 1 | 1 selects the 8-bit data path (split-strobe mode) |
| reg_addr | input | 5 | Register index in bits 4:1. Bit 0 is the byte address or the upper data strobe |
| bhe_n | input | 1 | Byte-high enable, or lower data strobe in acknowledge mode |
| reg_sel_n | input | 1 | Register bank select, active low |
| strb_rd_n | input | 1 | Read strobe, or address strobe in acknowledge mode |
| strb_wr_n | input | 1 | Write strobe, or read/write line in acknowledge mode |
| mem_sel_n | input | 1 | Memory cycle select, active low |
| mem_rd_n | input | 1 | Memory read strobe (split-strobe mode) |
| mem_wr_n | input | 1 | Memory write strobe (split-strobe mode) |
| data_in | input | 16 | Data from host |
| data_out | output | 16 | Data to host |
| data_oe | output | 1 | Drive enable for data_out |
| rdy_out | output | 1 | Ready pin level |
| rdy_oe | output | 1 | Drive enable for the ready pin |
| mem_req | output | 1 | One-clock memory cycle request |
| mem_we | output | 1 | Direction of the last memory request (1 write) |

## Verification
If the cycle sequencer loses its state, the ready pin shows it within five clocks of a strobe edge: the drive enable stays up after release, or the ready level flips at the wrong clock. A corrupted lane decode does not show at the pins until the register is read back, so every write is followed by a read of the whole word, which also exposes a lane that should have kept its value. A memory detector that retriggers shows a second request pulse inside the same host cycle.

// File: rtl/hbr_pkg.sv
// Shared types for the host bus register interface.
// Assumes a 16-bit host data bus split into two byte lanes.
package hbr_pkg;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_WAIT = 2'd1,
        CYC_HOLD = 2'd2
    } cyc_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } lane_sel_t;
endpackage

// File: rtl/hbr_sync.sv
// Multi-stage synchronizer for asynchronous host pins.
// Assumes each bit is an independent level; no bus coherency is implied.
module hbr_sync #(
    parameter int W       = 1,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/hbr_cycle_ctrl.sv
// Register cycle sequencer: idle, waiting for a fixed count, then holding
// the completion level until the host withdraws the request.
// Assumes req and req_read are already synchronized and mode_ack is static.
module hbr_cycle_ctrl
    import hbr_pkg::*;
#(
    parameter int WAIT_CLKS = 2,
    parameter int ACK_CLKS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ack,
    input  logic req,
    input  logic req_read,
    output logic start,
    output logic commit,
    output logic rd_cyc,
    output logic rdy_oe,
    output logic rdy_out,
    output logic data_oe
);
    localparam int MAXD  = (WAIT_CLKS > ACK_CLKS) ? WAIT_CLKS : ACK_CLKS;
    localparam int CNT_W = (MAXD < 2) ? 1 : $clog2(MAXD + 1);

    cyc_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rd_q;

    assign start  = (st_q == CYC_IDLE) && req;
    assign commit = (st_q == CYC_WAIT) && req && (cnt_q == '0);

    // Advance the cycle state and its wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CYC_IDLE;
            cnt_q <= '0;
            rd_q  <= 1'b0;
        end else begin
            unique case (st_q)
                CYC_IDLE: if (req) begin
                    st_q  <= CYC_WAIT;
                    cnt_q <= mode_ack ? CNT_W'(ACK_CLKS - 1) : CNT_W'(WAIT_CLKS - 1);
                    rd_q  <= req_read;
                end
                CYC_WAIT: begin
                    if (!req)              st_q <= CYC_IDLE;
                    else if (cnt_q == '0)  st_q <= CYC_HOLD;
                    else                   cnt_q <= cnt_q - 1'b1;
                end
                CYC_HOLD: if (!req) st_q <= CYC_IDLE;
                default:  st_q <= CYC_IDLE;
            endcase
        end
    end

    // Map state to pin levels for the selected bus style.
    always_comb begin
        rdy_oe  = (st_q != CYC_IDLE);
        rdy_out = mode_ack ? (st_q != CYC_HOLD) : (st_q == CYC_HOLD);
        data_oe = (st_q != CYC_IDLE) && rd_q && req;
        rd_cyc  = rd_q;
    end

    // R4, R5: one clock after the commit point the completion level is driven.
    assert_done_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (rdy_oe && (rdy_out == !mode_ack)));

    // R6: the ready pin is only driven when a request was present.
    assert_oe_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_oe |-> $past(req));

    // R3: data is never driven on a cycle that started as a write.
    assert_read_only_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !req_read) |=> !data_oe);
endmodule

// File: rtl/hbr_regfile.sv
// Bank of byte-lane-writable registers with one write and one read port.
// Assumes wr_idx and rd_idx are always below NUM_REGS.
module hbr_regfile
    import hbr_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LANES-1:0]  byte_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_REGS*DATA_W-1:0] flat;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            logic [7:0] cell_q;

            // Load one byte cell when its register and lane are selected.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= '0;
                else if (wr_en && (wr_idx == IDX_W'(r)) && byte_we[b])
                    cell_q <= wr_data[b*8 +: 8];
            end

            assign flat[r*DATA_W + b*8 +: 8] = cell_q;
        end
    end

    assign rd_data = flat[rd_idx*DATA_W +: DATA_W];

    // R2, R6: without a write, no register bit moves.
    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flat));
endmodule

// File: rtl/hbr_mem_detect.sv
// Memory cycle detector: one request pulse per host memory cycle.
// Assumes synchronized, active-low inputs and a static mode.
module hbr_mem_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ack,
    input  logic sel_s_n,
    input  logic rd_s_n,
    input  logic wr_s_n,
    input  logic as_s_n,
    input  logic rw_s,
    output logic mem_req,
    output logic mem_we
);
    logic active, is_wr, prev_q;

    // Decode cycle presence and direction for the chosen bus style.
    always_comb begin
        if (mode_ack) begin
            active = !sel_s_n && !as_s_n;
            is_wr  = !rw_s;
        end else begin
            active = !sel_s_n && (!rd_s_n || !wr_s_n);
            is_wr  = !wr_s_n;
        end
    end

    // Emit a pulse on cycle start and capture its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
        end else begin
            prev_q  <= active;
            mem_req <= active && !prev_q;
            if (active && !prev_q) mem_we <= is_wr;
        end
    end

    // R9: requests are single-clock pulses.
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R10: direction only changes together with a new request.
    assert_dir_with_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_we) |-> mem_req);
endmodule

// File: rtl/host_bus_regif.sv
// Host bus slave for a register bank, in split-strobe or acknowledge style.
// Assumes mode_ack and bus8 are static, and that address, byte enables and
// write data are stable while a strobe is asserted.
module host_bus_regif
    import hbr_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int WAIT_CLKS   = 2,
    parameter int ACK_CLKS    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ack,
    input  logic              bus8,
    input  logic [IDX_W:0]    reg_addr,
    input  logic              bhe_n,
    input  logic              reg_sel_n,
    input  logic              strb_rd_n,
    input  logic              strb_wr_n,
    input  logic              mem_sel_n,
    input  logic              mem_rd_n,
    input  logic              mem_wr_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rdy_out,
    output logic              rdy_oe,
    output logic              mem_req,
    output logic              mem_we
);
    logic [5:0] pins_s;
    logic cs_s_n, rd_s_n, wr_s_n, msel_s_n, mrd_s_n, mwr_s_n;

    hbr_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'h3F)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({reg_sel_n, strb_rd_n, strb_wr_n, mem_sel_n, mem_rd_n, mem_wr_n}),
        .dout (pins_s)
    );
    assign {cs_s_n, rd_s_n, wr_s_n, msel_s_n, mrd_s_n, mwr_s_n} = pins_s;

    logic req, req_read, start, commit, rd_cyc;

    // Decode register cycle presence and direction per bus style.
    always_comb begin
        if (mode_ack) begin
            req      = !cs_s_n && !rd_s_n;
            req_read = wr_s_n;
        end else begin
            req      = !cs_s_n && (!rd_s_n || !wr_s_n);
            req_read = !rd_s_n;
        end
    end

    hbr_cycle_ctrl #(.WAIT_CLKS(WAIT_CLKS), .ACK_CLKS(ACK_CLKS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_ack(mode_ack),
        .req     (req),
        .req_read(req_read),
        .start   (start),
        .commit  (commit),
        .rd_cyc  (rd_cyc),
        .rdy_oe  (rdy_oe),
        .rdy_out (rdy_out),
        .data_oe (data_oe)
    );

    logic [IDX_W-1:0] idx_q;
    logic             a0_q;

    // Capture the register index and byte address when a cycle opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            a0_q  <= 1'b0;
        end else if (start) begin
            idx_q <= reg_addr[IDX_W:1];
            a0_q  <= reg_addr[0];
        end
    end

    lane_sel_t         lanes;
    logic [DATA_W-1:0] wdata;

    // Select byte lanes and write data for the bus style and width.
    always_comb begin
        if (mode_ack) begin
            lanes.hi = !reg_addr[0];
            lanes.lo = !bhe_n;
            wdata    = data_in;
        end else if (bus8) begin
            lanes.hi = reg_addr[0];
            lanes.lo = !reg_addr[0];
            wdata    = {data_in[7:0], data_in[7:0]};
        end else begin
            lanes.hi = !bhe_n;
            lanes.lo = !reg_addr[0];
            wdata    = data_in;
        end
    end

    logic [DATA_W-1:0] rd_word;

    hbr_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (commit && !rd_cyc),
        .wr_idx (idx_q),
        .byte_we({lanes.hi, lanes.lo}),
        .wr_data(wdata),
        .rd_idx (idx_q),
        .rd_data(rd_word)
    );

    // Narrow read data to one byte on the 8-bit path.
    always_comb begin
        if (bus8 && !mode_ack)
            data_out = {8'h00, (a0_q ? rd_word[15:8] : rd_word[7:0])};
        else
            data_out = rd_word;
    end

    hbr_mem_detect u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_ack(mode_ack),
        .sel_s_n (msel_s_n),
        .rd_s_n  (mrd_s_n),
        .wr_s_n  (mwr_s_n),
        .as_s_n  (rd_s_n),
        .rw_s    (wr_s_n),
        .mem_req (mem_req),
        .mem_we  (mem_we)
    );

    // R6: a cycle never starts without the register select.
    assert_select_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_oe) |-> !$past(cs_s_n));

    // R8: on the 8-bit path the upper data lanes stay quiet.
    assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus8 && !mode_ack && data_oe) |-> (data_out[15:8] == 8'h00));
endmodule

// File: tb/sim_host_bus_regif.sv
`timescale 1ns/1ps
module sim_host_bus_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_ack = 1'b0, bus8 = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        bhe_n = 1'b1, reg_sel_n = 1'b1, strb_rd_n = 1'b1, strb_wr_n = 1'b1;
    logic        mem_sel_n = 1'b1, mem_rd_n = 1'b1, mem_wr_n = 1'b1;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic        data_oe, rdy_out, rdy_oe, mem_req, mem_we;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    host_bus_regif u0 (
        .clk(clk), .rst_n(rst_n), .mode_ack(mode_ack), .bus8(bus8),
        .reg_addr(reg_addr), .bhe_n(bhe_n), .reg_sel_n(reg_sel_n),
        .strb_rd_n(strb_rd_n), .strb_wr_n(strb_wr_n), .mem_sel_n(mem_sel_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .rdy_out(rdy_out),
        .rdy_oe(rdy_oe), .mem_req(mem_req), .mem_we(mem_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // One register cycle; samples data after six clocks, then releases.
    task automatic bus_cycle(input bit ack, input bit rd, input logic [3:0] idx,
                             input bit a0, input bit bhe, input logic [15:0] d,
                             output logic [15:0] rdata, output logic doe);
        @(negedge clk);
        mode_ack = ack; reg_addr = {idx, a0}; bhe_n = bhe; data_in = d; reg_sel_n = 1'b0;
        if (ack) begin strb_wr_n = rd; strb_rd_n = 1'b0; end
        else if (rd) strb_rd_n = 1'b0;
        else strb_wr_n = 1'b0;
        repeat (6) @(negedge clk);
        rdata = data_out; doe = data_oe;
        reg_sel_n = 1'b1; strb_rd_n = 1'b1; strb_wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic rd_word(input bit ack, input logic [3:0] idx, output logic [15:0] v);
        logic doe;
        bus_cycle(ack, 1'b1, idx, 1'b0, 1'b0, 16'h0000, v, doe);
    endtask

    task automatic wr_word(input bit ack, input logic [3:0] idx, input bit a0,
                           input bit bhe, input logic [15:0] d, output logic doe);
        logic [15:0] v;
        bus_cycle(ack, 1'b0, idx, a0, bhe, d, v, doe);
    endtask

    task automatic t_reset_state;
        chk("R1 rdy_oe after reset", rdy_oe, 0);
        chk("R1 data_oe after reset", data_oe, 0);
        chk("R1 mem_req after reset", mem_req, 0);
    endtask

    task automatic t_split_lanes;
        logic doe; logic [15:0] v;
        bus8 = 1'b0;
        wr_word(1'b0, 4'd5, 1'b0, 1'b0, 16'h1234, doe);
        chk("R3 no data drive on write", doe, 0);
        rd_word(1'b0, 4'd5, v);
        chk("R2 full word write", v, 16'h1234);
        wr_word(1'b0, 4'd5, 1'b1, 1'b0, 16'hABCD, doe);
        rd_word(1'b0, 4'd5, v);
        chk("R2 high lane only", v, 16'hAB34);
        wr_word(1'b0, 4'd5, 1'b0, 1'b1, 16'hEEFF, doe);
        rd_word(1'b0, 4'd5, v);
        chk("R2 low lane only", v, 16'hABFF);
        wr_word(1'b0, 4'd0, 1'b0, 1'b0, 16'hA5A5, doe);
        wr_word(1'b0, 4'd15, 1'b0, 1'b0, 16'h5A5A, doe);
        rd_word(1'b0, 4'd0, v);
        chk("R2 index 0", v, 16'hA5A5);
        rd_word(1'b0, 4'd15, v);
        chk("R2 index 15", v, 16'h5A5A);
        rd_word(1'b0, 4'd5, v);
        chk("R2 index 5 untouched by others", v, 16'hABFF);
    endtask

    // Cycle timing of ready and data enables; ack selects the bus style.
    task automatic t_timing(input bit ack);
        string tag;
        tag = ack ? "R5" : "R4";
        @(negedge clk);
        mode_ack = ack; reg_addr = {4'd5, 1'b0}; bhe_n = 1'b0; reg_sel_n = 1'b0;
        strb_wr_n = 1'b1; strb_rd_n = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            chk($sformatf("%s rdy_oe clock %0d", tag, k), rdy_oe, (k >= 3));
            if (k >= 3)
                chk($sformatf("%s rdy_out clock %0d", tag, k), rdy_out,
                    ack ? (k < 5) : (k >= 5));
            if (k == 3) chk("R3 data_oe on read", data_oe, 1);
        end
        chk("R3 read data", data_out, 16'hABFF);
        reg_sel_n = 1'b1; strb_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 still driven before release", rdy_oe, 1);
        @(negedge clk);
        chk("R6 released", rdy_oe, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_ack_lanes;
        logic doe; logic [15:0] v;
        wr_word(1'b1, 4'd10, 1'b0, 1'b0, 16'h1357, doe);
        chk("R7 write has no data drive", doe, 0);
        wr_word(1'b1, 4'd10, 1'b1, 1'b0, 16'hFFFF, doe);
        wr_word(1'b1, 4'd10, 1'b0, 1'b1, 16'h2400, doe);
        bus_cycle(1'b1, 1'b1, 4'd10, 1'b0, 1'b0, 16'h0000, v, doe);
        chk("R7 lanes via data strobes", v, 16'h24FF);
        chk("R7 read drives data", doe, 1);
    endtask

    task automatic t_narrow;
        logic doe; logic [15:0] v;
        bus8 = 1'b1;
        wr_word(1'b0, 4'd3, 1'b0, 1'b0, 16'hFF5A, doe);
        wr_word(1'b0, 4'd3, 1'b1, 1'b0, 16'h77C3, doe);
        bus_cycle(1'b0, 1'b1, 4'd3, 1'b0, 1'b0, 16'h0, v, doe);
        chk("R8 low byte read", v, 16'h005A);
        bus_cycle(1'b0, 1'b1, 4'd3, 1'b1, 1'b0, 16'h0, v, doe);
        chk("R8 high byte read", v, 16'h00C3);
        bus8 = 1'b0;
        rd_word(1'b0, 4'd3, v);
        chk("R8 stored word", v, 16'hC35A);
    endtask

    task automatic t_no_select;
        int seen; logic [15:0] v;
        seen = 0;
        @(negedge clk);
        mode_ack = 1'b0; reg_addr = {4'd5, 1'b0}; bhe_n = 1'b0; data_in = 16'h0000;
        strb_wr_n = 1'b0;
        repeat (8) begin @(negedge clk); if (rdy_oe) seen++; end
        strb_wr_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 no drive without select", seen, 0);
        rd_word(1'b0, 4'd5, v);
        chk("R6 register untouched without select", v, 16'hABFF);
    endtask

    task automatic mem_probe(output int pulses, output logic we);
        pulses = 0; we = 1'bx;
        repeat (8) begin
            @(negedge clk);
            if (mem_req) begin pulses++; we = mem_we; end
        end
        mem_sel_n = 1'b1; mem_rd_n = 1'b1; mem_wr_n = 1'b1;
        strb_rd_n = 1'b1; strb_wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_mem;
        int p; logic we;
        @(negedge clk); mode_ack = 1'b0; mem_sel_n = 1'b0; mem_wr_n = 1'b0;
        mem_probe(p, we);
        chk("R9 write pulse count", p, 1); chk("R9 write dir", we, 1);
        @(negedge clk); mem_sel_n = 1'b0; mem_rd_n = 1'b0;
        mem_probe(p, we);
        chk("R9 read pulse count", p, 1); chk("R9 read dir", we, 0);
        @(negedge clk); mode_ack = 1'b1; mem_sel_n = 1'b0; strb_wr_n = 1'b0; strb_rd_n = 1'b0;
        mem_probe(p, we);
        chk("R10 ack write pulse", p, 1); chk("R10 ack write dir", we, 1);
        @(negedge clk); mem_sel_n = 1'b0; strb_wr_n = 1'b1; mem_wr_n = 1'b0; strb_rd_n = 1'b0;
        mem_probe(p, we);
        chk("R10 mem_wr_n ignored", we, 0);
        @(negedge clk); mem_sel_n = 1'b0; mem_wr_n = 1'b0;
        mem_probe(p, we);
        chk("R10 no pulse without address strobe", p, 0);
        mode_ack = 1'b0;
    endtask

    task automatic t_reset_clear;
        logic [15:0] v;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        t_reset_state;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd_word(1'b0, 4'd5, v);
        chk("R1 register cleared", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_split_lanes;
        t_timing(1'b0);
        t_timing(1'b1);
        t_ack_lanes;
        t_narrow;
        t_no_select;
        t_mem;
        t_reset_clear;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule